// File: doc/BRIEF.md
# Pipelined Ripple Adder-Subtractor

This block adds or subtracts two WIDTH-bit two's-complement operands and picks the operation separately for each operand pair. One ripple-carry chain does both jobs. A subtract inverts every bit of the second operand and feeds a carry of one into bit 0, which gives `A - B = A + ~B + 1`. The carry out of the top bit is dropped, so every result wraps modulo 2^WIDTH.

To shorten the critical path, the chain can be cut into `2^LEVELS` equal ripple segments, with a register on each carry between segments. Operand bits for later segments are skewed by extra register stages so that they reach their segment in the same cycle as the incoming carry. Result bits from earlier segments are held back so that all result bits of one operation leave together through an output register. A valid flag follows the data through the same number of stages. The block takes a new operand pair every clock and gives one result every clock, `2^LEVELS` cycles after the operands were presented.

Top module: `addsub_pipe`

## Requirements
- R1: With `in_sub`=0 on a valid input, `out_sum` equals `(in_a + in_b) mod 2^WIDTH`.
- R2: With `in_sub`=1 on a valid input, `out_sum` equals `(in_a - in_b) mod 2^WIDTH`. This is built as `in_a + ~in_b` with a carry of one into bit 0.
- R3: The carry out of the most significant bit is discarded. For example, `all-ones + 1` gives 0 and `0 - 1` gives all ones.
- R4: A result appears on `out_sum`, with `out_valid`=1, exactly `2^LEVELS` clock cycles after its operands were sampled with `in_valid`=1. `out_valid` is never 1 without a matching earlier input.
- R5: The block accepts one operand pair every cycle with no bubbles, even when `in_sub` changes from one cycle to the next. Results leave in input order, one per cycle.
- R6: `rst` (synchronous, active high) clears every valid stage. `out_valid` is 0 while `rst` is held and for the first `2^LEVELS` cycles after it is released. Operations in flight when reset arrives are dropped. Data registers are not reset.
- R7: WIDTH must be a power of two and LEVELS must lie in 0 .. log2(WIDTH)-1, so the smallest segment is two bits. At LEVELS = log2(WIDTH)-1 results stay correct. Any other configuration is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Operand pair on this cycle is to be processed |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_sub | input | 1 | 1 = subtract `in_b` from `in_a`, 0 = add |
| out_valid | output | 1 | `out_sum` holds a result this cycle |
| out_sum | output | WIDTH | Registered result, modulo 2^WIDTH |

## Verification
If an inter-segment carry register or a skew stage is wrong, only the upper segments of the result are off, by exactly one unit at a segment boundary. Such an error shows `2^LEVELS` cycles after the input, and only for operand pairs whose carry crosses that boundary. The stimulus therefore mixes random operands with all-ones and zero patterns that carry across every boundary, and it toggles `in_sub` every cycle so that a misaligned sub bit shows up on the next result. If a valid stage is wrong, `out_valid` is early, late or extra, so every result is checked against the exact cycle its operands entered.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // True when v is a nonzero power of two.
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Integer log2, rounded down.
  function automatic int unsigned floor_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int unsigned t = v; t > 1; t = t >> 1) r++;
    return r;
  endfunction

endpackage

// File: rtl/addsub_delay.sv
// Plain register delay line of DEPTH (>= 1) stages, no reset.
module addsub_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    stage[0] <= din;
    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/addsub_ripple_seg.sv
// One ripple segment: per bit, operand b is XORed with sub, then a full adder.
module addsub_ripple_seg #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout
);
  logic [SEG_W:0]   chain;
  logic [SEG_W-1:0] bx;

  always_comb begin
    chain[0] = cin;
    for (int i = 0; i < SEG_W; i++) begin
      bx[i]       = b[i] ^ sub;
      sum[i]      = a[i] ^ bx[i] ^ chain[i];
      chain[i+1]  = (a[i] & bx[i]) | (a[i] & chain[i]) | (bx[i] & chain[i]);
    end
    cout = chain[SEG_W];
    // R1 R2: gate-level chain agrees with a wide add of a, conditionally inverted b and cin
    if (!$isunknown({a, b, sub, cin}))
      assert_seg_sum_R1: assert ({cout, sum} ==
        ({1'b0, a} + {1'b0, (b ^ {SEG_W{sub}})} + (SEG_W+1)'(cin)));
  end
endmodule

// File: rtl/addsub_pipe.sv
module addsub_pipe
  import addsub_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LEVELS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_sub,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum
);
  localparam int SEGS    = 1 << LEVELS;
  localparam int SEG_W   = WIDTH / SEGS;
  localparam int LATENCY = SEGS;
  localparam int CW      = $clog2(LATENCY + 1) + 1;

  initial begin
    assert_params_R7: assert (is_pow2(WIDTH) && (WIDTH >= 2) && (LEVELS >= 0) &&
                              (LEVELS <= int'(floor_log2(WIDTH)) - 1));
  end

  logic [SEGS-1:0]  seg_cout;
  logic [WIDTH-1:0] sum_aligned;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    logic [2*SEG_W:0] ops_k;
    logic [SEG_W-1:0] a_k, b_k, sum_k;
    logic             sub_k, cin_k, cout_k;

    // skew: segment k sees its operands k cycles late
    if (k == 0) begin : g_noskew
      assign ops_k = {in_sub, in_a[k*SEG_W +: SEG_W], in_b[k*SEG_W +: SEG_W]};
    end else begin : g_skew
      addsub_delay #(.W(2*SEG_W+1), .DEPTH(k)) u_skew (
        .clk  (clk),
        .din  ({in_sub, in_a[k*SEG_W +: SEG_W], in_b[k*SEG_W +: SEG_W]}),
        .dout (ops_k)
      );
    end
    assign {sub_k, a_k, b_k} = ops_k;

    // carry into segment: sub for the lowest, registered neighbour carry otherwise
    if (k == 0) begin : g_cin0
      assign cin_k = sub_k;
    end else begin : g_cinreg
      logic carry_q;
      always_ff @(posedge clk) carry_q <= seg_cout[k-1];
      assign cin_k = carry_q;
    end

    addsub_ripple_seg #(.SEG_W(SEG_W)) u_seg (
      .a    (a_k),
      .b    (b_k),
      .sub  (sub_k),
      .cin  (cin_k),
      .sum  (sum_k),
      .cout (cout_k)
    );
    assign seg_cout[k] = cout_k;

    // deskew: segment k waits SEGS-1-k more cycles
    if (k == SEGS - 1) begin : g_nodeskew
      assign sum_aligned[k*SEG_W +: SEG_W] = sum_k;
    end else begin : g_deskew
      addsub_delay #(.W(SEG_W), .DEPTH(SEGS-1-k)) u_deskew (
        .clk  (clk),
        .din  (sum_k),
        .dout (sum_aligned[k*SEG_W +: SEG_W])
      );
    end

    // R3: a dropped carry means the segment wrapped, so its sum cannot exceed a
    assert_wrap_order_R3: assert property (@(posedge clk) disable iff (rst)
      (!$isunknown({a_k, b_k, sub_k, cin_k}) && seg_cout[k]) |-> (sum_k <= a_k));
  end

  // registered result
  always_ff @(posedge clk) out_sum <= sum_aligned;

  // valid travels through LATENCY stages
  logic [LATENCY-1:0] vld_sr;
  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= LATENCY'({vld_sr, in_valid});
  end
  assign out_valid = vld_sr[LATENCY-1];

  // checker state
  logic [CW-1:0] warm_cnt;
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt <= '0;
      inflight <= '0;
    end else begin
      if (warm_cnt < CW'(LATENCY)) warm_cnt <= warm_cnt + 1'b1;
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end
  end

  assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt < CW'(LATENCY)) |-> !out_valid);

  assert_no_orphan_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  assert_depth_R5: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LATENCY));
endmodule

// File: tb/test_addsub_pipe.sv
module test_harness #(
  parameter int W = 8,
  parameter int L = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] a16,
  input  logic [15:0] b16,
  input  logic        sub,
  output int          checks,
  output int          errs
);
  localparam int LAT = 1 << L;
  localparam int P   = $clog2(W);

  logic         out_valid;
  logic [W-1:0] out_sum;

  addsub_pipe #(.WIDTH(W), .LEVELS(L)) i_addsub_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (a16[W-1:0]),
    .in_b      (b16[W-1:0]),
    .in_sub    (sub),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  typedef struct {
    int           stamp;
    logic [W-1:0] exp;
    logic         sub;
    logic         wrap;
  } ent_t;

  ent_t q[$];
  int   cyc = 0;
  logic rst_prev = 1'b0;

  initial begin
    checks = 0;
    errs   = 0;
  end

  always @(negedge clk) begin
    ent_t e;
    string tag;
    int    ai, bi, full;
    if (rst) begin
      q.delete();
      if (rst_prev) begin
        checks++;
        if (out_valid !== 1'b0) begin
          errs++;
          $display("FAIL R6 W=%0d L=%0d: out_valid=%b expected 0 in reset", W, L, out_valid);
        end
      end
    end else begin
      if (out_valid) begin
        checks++;
        if (q.size() == 0) begin
          errs++;
          $display("FAIL R4 W=%0d L=%0d: out_valid=1 expected 0 (no pending op) cyc %0d", W, L, cyc);
        end else begin
          e = q.pop_front();
          if (e.stamp + LAT != cyc) begin
            errs++;
            $display("FAIL R4 W=%0d L=%0d: latency %0d expected %0d", W, L, cyc - e.stamp, LAT);
          end
          checks++;
          tag = e.wrap ? "R3" : (e.sub ? "R2" : "R1");
          if (L == P - 1) tag = {tag, " R7"};
          if (out_sum !== e.exp) begin
            errs++;
            $display("FAIL %s W=%0d L=%0d: sum=%h expected %h", tag, W, L, out_sum, e.exp);
          end
        end
      end else if (q.size() > 0 && q[0].stamp + LAT == cyc) begin
        checks++;
        errs++;
        $display("FAIL R5 W=%0d L=%0d: out_valid=0 expected 1 at cyc %0d", W, L, cyc);
        void'(q.pop_front());
      end
      if (in_valid) begin
        ai   = int'(a16[W-1:0]);
        bi   = int'(b16[W-1:0]);
        full = sub ? (ai - bi) : (ai + bi);
        e.stamp = cyc;
        e.exp   = W'(full);
        e.sub   = sub;
        e.wrap  = sub ? (ai < bi) : (full >= (1 << W));
        q.push_back(e);
      end
    end
    rst_prev = rst;
    cyc++;
  end
endmodule

module test_addsub_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int NINST      = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic        sub = 1'b0;
  logic        done = 1'b0;
  int          ck [NINST];
  int          er [NINST];

  always #(CLK_PERIOD/2) clk = ~clk;

  // N=8: L=0..2, N=16: L=0..3 (the top module instance inside each harness is i_addsub_pipe)
  for (genvar g = 0; g < 3; g++) begin : g_w8
    test_harness #(.W(8), .L(g)) u_h (
      .clk(clk), .rst(rst), .in_valid(vld), .a16(opa), .b16(opb), .sub(sub),
      .checks(ck[g]), .errs(er[g]));
  end
  for (genvar g = 0; g < 4; g++) begin : g_w16
    test_harness #(.W(16), .L(g)) u_h (
      .clk(clk), .rst(rst), .in_valid(vld), .a16(opa), .b16(opb), .sub(sub),
      .checks(ck[3+g]), .errs(er[3+g]));
  end

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic s);
    @(posedge clk);
    #2;
    vld = v; opa = a; opb = b; sub = s;
  endtask

  task automatic report(input int extra_err);
    int c, e;
    c = extra_err;
    e = extra_err;
    for (int i = 0; i < NINST; i++) begin
      c += ck[i];
      e += er[i];
    end
    $display("Simulation finished: %0d checks, %0d errors", c, e);
  endtask

  initial begin
    repeat (4) step(1'b0, '0, '0, 1'b0);          // R6 checked while held
    @(posedge clk); #2; rst = 1'b0;
    // directed: R1, R3 wrap on add, R2, R3 borrow wrap, cross-boundary carries
    step(1'b1, 16'h0000, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 16'h0001, 1'b0);
    step(1'b1, 16'h0000, 16'h0001, 1'b1);
    step(1'b1, 16'h1234, 16'h1234, 1'b1);
    step(1'b1, 16'h7F7F, 16'h0101, 1'b0);
    step(1'b1, 16'h8000, 16'h0001, 1'b1);
    step(1'b1, 16'h5555, 16'hAAAB, 1'b0);
    step(1'b1, 16'h0100, 16'h00FF, 1'b1);
    // R5: back-to-back, sub toggling every cycle
    for (int i = 0; i < 600; i++)
      step(1'b1, 16'($urandom), 16'($urandom), i[0]);
    // gaps in the valid stream
    for (int i = 0; i < 300; i++)
      step(1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    // R6: reset with operations in flight
    step(1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    @(posedge clk); #2; rst = 1'b1;
    repeat (3) step(1'b1, 16'($urandom), 16'($urandom), 1'b1);
    @(posedge clk); #2; rst = 1'b0; vld = 1'b0;
    repeat (10) step(1'b0, '0, '0, 1'b0);
    for (int i = 0; i < 200; i++)
      step(1'b1, 16'($urandom), 16'($urandom), ~i[0]);
    repeat (40) step(1'b0, '0, '0, 1'b0);
    done = 1'b1;
    report(0);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: run did not complete, expected completion");
      report(1);
      $finish;
    end
  end
endmodule